// File: doc/BRIEF.md
# Scalar Add-Then-Reciprocal Unit

This unit is a single scalar arithmetic path placed beside a wide parallel datapath. In one operation it adds or subtracts two signed Q16.16 values. It then either stops there, or passes that sum through an iterative restoring divider to form its reciprocal. A typical use is a filter update step. The add form produces a projected variance plus a sensor noise term, which becomes a gain denominator once the reciprocal is taken. The subtract form produces a measurement minus a predicted value.

One operand always comes from a small private operand store. That store holds two words per sensor: a noise variance and a measurement. The other operand arrives on the reduction-result input. The sum and the reciprocal leave on two separate outputs, each with its own valid strobe, so a caller can route the sum to one storage bank and the reciprocal to another. A new operation is accepted only while the unit is idle.

Top module: `sar_unit`

## Requirements
- R1: After reset, `busy`, `sum_valid`, `recip_valid` and `div_by_zero` are low, and every operand-store word reads as zero.
- R2: When `start` is high in a cycle with `busy` low and `op_sub`=0, the unit computes variance[`sensor_idx`] + `reduce_in`. `sum_out` carries this result and `sum_valid` is high for exactly one cycle, ADD_LAT (12) cycles after the start cycle.
- R3: With `op_sub`=1, the same timing applies and `sum_out` is measurement[`sensor_idx`] − `reduce_in`.
- R4: A sum that leaves the signed 32-bit range is clamped, to 0x7FFFFFFF on the high side and to 0x80000000 on the low side.
- R5: When `op_recip`=1 at the start, `recip_out` is the reciprocal of the sum. Its magnitude is floor(2^32/|sum|), clamped to 0x7FFFFFFF, and it carries the sign of the sum. `recip_valid` is high for one cycle, ADD_LAT+DIV_LAT (42) cycles after the start cycle. When `op_recip`=0, `recip_valid` stays low.
- R6: A zero sum with `op_recip`=1 sets `div_by_zero` high together with `recip_valid`, and `recip_out` is then 0x7FFFFFFF. `div_by_zero` is never high without `recip_valid`.
- R7: `busy` is high from the cycle after a start is accepted up to the cycle before the last strobe of that operation. `busy` is low in the cycle of that last strobe. A `start` given while `busy` is high is ignored and produces no strobe.
- R8: The operand store is addressed by sensor number 1..P. When `wr_meas`=0 a write goes to the variance word, and when `wr_meas`=1 it goes to the measurement word. Writes to index 0 or to an index above P are discarded, and an operation that names such an index uses a zero store operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_sub | input | 1 | 0: variance + reduce_in, 1: measurement − reduce_in |
| op_recip | input | 1 | Also form the reciprocal of the sum |
| sensor_idx | input | IW | Sensor number selecting the stored operand |
| reduce_in | input | W | Second operand from the reduction output |
| wr_en | input | 1 | Operand-store write enable |
| wr_idx | input | IW | Sensor number for the write |
| wr_meas | input | 1 | Write target: 0 variance, 1 measurement |
| wr_data | input | W | Q16.16 word to store |
| busy | output | 1 | Operation in flight |
| sum_valid | output | 1 | One-cycle strobe for sum_out |
| sum_out | output | W | Saturated Q16.16 sum or difference |
| recip_valid | output | 1 | One-cycle strobe for recip_out |
| recip_out | output | W | Q16.16 reciprocal of the sum |
| div_by_zero | output | 1 | Sum was zero (qualified by recip_valid) |

## Verification
The bench uses the default build: 32-bit words with 16 fraction bits, four sensors, 2 quotient bits per divider cycle, and latencies of 12 and 42. With four sensors the 3-bit index can name 0 and 5..7, so writes and reads outside the range can be driven at the ports. The full word width lets both saturation edges, the most negative denominator and a sum of ±1 (whose unclamped reciprocal, 2^32, does not fit) be driven directly. Random operations then mix full-range and small operands under both modes, with and without the reciprocal.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic {
      SAR_ADD = 1'b0,
      SAR_SUB = 1'b1
   } sar_op_e;

   typedef enum logic {
      SAR_SLOT_VAR  = 1'b0,
      SAR_SLOT_MEAS = 1'b1
   } sar_slot_e;
endpackage

// File: rtl/sar_opmem.sv
module sar_opmem #(
   parameter int P  = 4,
   parameter int W  = 32,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic          wslot,
   input  logic [W-1:0]  wdata,
   input  logic [IW-1:0] ridx,
   output logic [W-1:0]  rvar,
   output logic [W-1:0]  rmeas
);
   localparam int DEPTH = 2 * P;

   initial begin
      assert (P >= 1 && (P + 1) <= (1 << IW))
         else $error("sar_opmem: index width cannot hold 1..P");
   end

   logic [W-1:0] words [DEPTH];
   logic         w_ok;
   logic         r_ok;
   int unsigned  w_addr;
   int unsigned  r_base;

   assign w_ok   = (widx != '0) && (int'(widx) <= P);
   assign r_ok   = (ridx != '0) && (int'(ridx) <= P);
   assign w_addr = 2 * (int'(widx) - 1) + int'(wslot);
   assign r_base = 2 * (int'(ridx) - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) words[i] <= '0;
      end else if (we && w_ok) begin
         words[w_addr[$clog2(DEPTH+1)-1:0]] <= wdata;
      end
   end

   always_comb begin
      rvar  = '0;
      rmeas = '0;
      if (r_ok) begin
         rvar  = words[r_base[$clog2(DEPTH+1)-1:0]];
         rmeas = words[r_base[$clog2(DEPTH+1)-1:0] + 1'b1];
      end
   end
endmodule

// File: rtl/sar_addpipe.sv
module sar_addpipe #(
   parameter int W   = 32,
   parameter int LAT = 12,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic         in_sub,
   input  logic         in_tag,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         out_vld,
   output logic         out_tag,
   output logic [W-1:0] out_sum
);
   localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

   initial begin
      assert (LAT >= 2) else $error("sar_addpipe: LAT must be at least 2");
   end

   logic [W:0]   wide;
   logic [W-1:0] res0;
   logic         vld [LAT];
   logic         tag [LAT];
   logic [W-1:0] dat [LAT];

   assign wide = in_sub ? ({a[W-1], a} - {b[W-1], b})
                        : ({a[W-1], a} + {b[W-1], b});

   generate
      if (SAT) begin : g_sat
         always_comb begin
            if (wide[W] != wide[W-1]) res0 = wide[W] ? MINV : MAXV;
            else                      res0 = wide[W-1:0];
         end
      end else begin : g_wrap
         assign res0 = wide[W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld[0] <= 1'b0;
         tag[0] <= 1'b0;
         dat[0] <= '0;
      end else begin
         vld[0] <= in_vld;
         tag[0] <= in_tag;
         dat[0] <= res0;
      end
   end

   for (genvar s = 1; s < LAT; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld[s] <= 1'b0;
            tag[s] <= 1'b0;
            dat[s] <= '0;
         end else begin
            vld[s] <= vld[s-1];
            tag[s] <= tag[s-1];
            dat[s] <= dat[s-1];
         end
      end
   end

   assign out_vld = vld[LAT-1];
   assign out_tag = tag[LAT-1];
   assign out_sum = dat[LAT-1];

   p_sum_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |=> !out_vld);
endmodule

// File: rtl/sar_recip.sv
module sar_recip #(
   parameter int W    = 32,
   parameter int FRAC = 16,
   parameter int LAT  = 30,
   parameter int BPC  = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] den,
   output logic         valid,
   output logic [W-1:0] res,
   output logic         dbz
);
   localparam int NUMW  = 2 * FRAC + 1;
   localparam int NITER = (NUMW + BPC - 1) / BPC;
   localparam int SHW   = NITER * BPC;
   localparam int DW    = W + 1;
   localparam int CW    = $clog2(LAT + 1);
   localparam int ITW   = $clog2(NITER + 1);
   localparam logic [W-1:0]   MAXV  = {1'b0, {(W-1){1'b1}}};
   localparam logic [SHW-1:0] ONE_N = SHW'(1) << (2 * FRAC);

   initial begin
      assert (LAT >= NITER + 2) else $error("sar_recip: LAT too short for BPC");
      assert (SHW > W) else $error("sar_recip: quotient narrower than result");
   end

   logic [SHW-1:0] num_q, num_n;
   logic [SHW-1:0] quo_q, quo_n;
   logic [DW-1:0]  rem_q, rem_n;
   logic [DW-1:0]  dmag;
   logic           neg, zero;
   logic [CW-1:0]  cnt;
   logic [ITW-1:0] iter;
   logic [SHW-1:0] clamp;
   logic [DW-1:0]  den_ext;

   assign den_ext = {den[W-1], den};

   always_comb begin
      num_n = num_q;
      quo_n = quo_q;
      rem_n = rem_q;
      for (int s = 0; s < BPC; s++) begin
         rem_n = {rem_n[DW-2:0], num_n[SHW-1]};
         num_n = num_n << 1;
         if (rem_n >= dmag) begin
            rem_n = rem_n - dmag;
            quo_n = {quo_n[SHW-2:0], 1'b1};
         end else begin
            quo_n = {quo_n[SHW-2:0], 1'b0};
         end
      end
   end

   always_comb begin
      if (zero || quo_q > SHW'(MAXV)) clamp = SHW'(MAXV);
      else                            clamp = quo_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         num_q <= '0;  quo_q <= '0;  rem_q <= '0;  dmag <= '0;
         neg   <= 1'b0; zero <= 1'b0; cnt <= '0;  iter <= '0;
         valid <= 1'b0; res  <= '0;   dbz <= 1'b0;
      end else if (load) begin
         num_q <= ONE_N;
         quo_q <= '0;
         rem_q <= '0;
         dmag  <= den[W-1] ? (~den_ext + 1'b1) : den_ext;
         neg   <= den[W-1];
         zero  <= (den == '0);
         cnt   <= CW'(LAT - 1);
         iter  <= '0;
         valid <= 1'b0;
         dbz   <= 1'b0;
      end else begin
         valid <= 1'b0;
         dbz   <= 1'b0;
         if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt > CW'(1) && iter < ITW'(NITER)) begin
               num_q <= num_n;
               quo_q <= quo_n;
               rem_q <= rem_n;
               iter  <= iter + 1'b1;
            end
            if (cnt == CW'(1)) begin
               valid <= 1'b1;
               dbz   <= zero;
               res   <= (neg && !zero) ? (~clamp[W-1:0] + 1'b1) : clamp[W-1:0];
            end
         end
      end
   end

   p_iter_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CW'(1)) |-> (iter == ITW'(NITER)));
   p_dbz_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dbz |-> valid);
   p_dbz_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dbz |-> (res == MAXV));
endmodule

// File: rtl/sar_unit.sv
module sar_unit #(
   parameter int W       = 32,
   parameter int FRAC    = 16,
   parameter int P       = 4,
   parameter int IW      = 3,
   parameter int ADD_LAT = 12,
   parameter int DIV_LAT = 30,
   parameter int BPC     = 2,
   parameter bit SAT     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          op_sub,
   input  logic          op_recip,
   input  logic [IW-1:0] sensor_idx,
   input  logic [W-1:0]  reduce_in,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic          wr_meas,
   input  logic [W-1:0]  wr_data,
   output logic          busy,
   output logic          sum_valid,
   output logic [W-1:0]  sum_out,
   output logic          recip_valid,
   output logic [W-1:0]  recip_out,
   output logic          div_by_zero
);
   import sar_pkg::*;

   localparam int TOT = ADD_LAT + DIV_LAT;
   localparam int CTW = $clog2(TOT + 2);

   initial begin
      assert (FRAC > 0 && FRAC < W) else $error("sar_unit: bad FRAC");
   end

   logic [W-1:0]   st_var, st_meas, op_a;
   logic           accept;
   logic           sum_tag;
   logic [CTW-1:0] life;
   sar_op_e        op_kind;

   assign op_kind = sar_op_e'(op_sub);
   assign op_a    = (op_kind == SAR_SUB) ? st_meas : st_var;
   assign accept  = start && !busy;
   assign busy    = life > CTW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)            life <= '0;
      else if (accept)       life <= op_recip ? CTW'(TOT) : CTW'(ADD_LAT);
      else if (life != '0)   life <= life - 1'b1;
   end

   sar_opmem #(.P(P), .W(W), .IW(IW)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en), .widx(wr_idx), .wslot(wr_meas), .wdata(wr_data),
      .ridx(sensor_idx), .rvar(st_var), .rmeas(st_meas)
   );

   sar_addpipe #(.W(W), .LAT(ADD_LAT), .SAT(SAT)) u_add (
      .clk(clk), .rst_n(rst_n),
      .in_vld(accept), .in_sub(op_kind == SAR_SUB), .in_tag(op_recip),
      .a(op_a), .b(reduce_in),
      .out_vld(sum_valid), .out_tag(sum_tag), .out_sum(sum_out)
   );

   sar_recip #(.W(W), .FRAC(FRAC), .LAT(DIV_LAT), .BPC(BPC)) u_rcp (
      .clk(clk), .rst_n(rst_n),
      .load(sum_valid && sum_tag), .den(sum_out),
      .valid(recip_valid), .res(recip_out), .dbz(div_by_zero)
   );

   p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (sum_valid || recip_valid));
   p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      recip_valid |-> !sum_valid);
   p_idle_at_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      recip_valid |-> !busy);
endmodule

// File: tb/sar_unit_tb.sv
module sar_unit_tb;
   localparam int AL = 12;
   localparam int DL = 30;
   localparam int NP = 4;
   localparam logic [31:0] MAXV = 32'h7FFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, op_sub = 1'b0, op_recip = 1'b0;
   logic [2:0]  sensor_idx = '0;
   logic [31:0] reduce_in = '0;
   logic        wr_en = 1'b0, wr_meas = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic        busy, sum_valid, recip_valid, div_by_zero;
   logic [31:0] sum_out, recip_out;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;
   logic [31:0] bm [8][2];

   always #5 clk = ~clk;

   sar_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub), .op_recip(op_recip),
      .sensor_idx(sensor_idx), .reduce_in(reduce_in), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_meas(wr_meas), .wr_data(wr_data), .busy(busy), .sum_valid(sum_valid),
      .sum_out(sum_out), .recip_valid(recip_valid), .recip_out(recip_out),
      .div_by_zero(div_by_zero)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] f_sum(logic [31:0] a, logic [31:0] b, bit sub);
      longint w;
      w = sub ? (longint'($signed(a)) - longint'($signed(b)))
              : (longint'($signed(a)) + longint'($signed(b)));
      if (w > 64'sd2147483647)  w = 64'sd2147483647;
      if (w < -64'sd2147483648) w = -64'sd2147483648;
      return w[31:0];
   endfunction

   function automatic bit f_ovf(logic [31:0] a, logic [31:0] b, bit sub);
      longint w;
      w = sub ? (longint'($signed(a)) - longint'($signed(b)))
              : (longint'($signed(a)) + longint'($signed(b)));
      return (w > 64'sd2147483647) || (w < -64'sd2147483648);
   endfunction

   function automatic logic [31:0] f_recip(logic [31:0] s);
      longint m, q;
      if (s == '0) return MAXV;
      m = $signed(s) < 0 ? -longint'($signed(s)) : longint'($signed(s));
      q = (longint'(1) <<< 32) / m;
      if (q > 64'sd2147483647) q = 64'sd2147483647;
      if ($signed(s) < 0) q = -q;
      return q[31:0];
   endfunction

   task automatic mem_wr(input logic [2:0] idx, input bit meas, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_meas = meas; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (idx >= 1 && idx <= NP) bm[idx][meas] = d;
   endtask

   task automatic run_op(input logic [2:0] idx, input bit sub, input bit rc,
                         input logic [31:0] red, input bit poke);
      logic [31:0] a, es, er, gs, gr;
      bit gd, bz_ok;
      int total, s_hits, s_at, r_hits, r_at;
      string tg;
      a  = (idx >= 1 && idx <= NP) ? bm[idx][sub] : 32'h0;
      es = f_sum(a, red, sub);
      er = f_recip(es);
      total = rc ? AL + DL : AL;
      s_hits = 0; s_at = -1; r_hits = 0; r_at = -1; bz_ok = 1'b1;
      gs = '0; gr = '0; gd = 1'b0;
      tg = (idx < 1 || idx > NP) ? "R8" : (f_ovf(a, red, sub) ? "R4" : (sub ? "R3" : "R2"));
      @(negedge clk);
      start = 1'b1; sensor_idx = idx; op_sub = sub; op_recip = rc; reduce_in = red;
      for (int k = 1; k <= total; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (k == 1) start = 1'b0;
         if (poke && k == 3) begin
            start = 1'b1; op_sub = ~sub; op_recip = 1'b1; reduce_in = 32'h0001_2345;
         end
         if (poke && k == 4) start = 1'b0;
         if (sum_valid) begin s_hits++; s_at = k; gs = sum_out; end
         if (recip_valid) begin r_hits++; r_at = k; gr = recip_out; gd = div_by_zero; end
         if (k < total && !busy) bz_ok = 1'b0;
         if (k == total && busy) bz_ok = 1'b0;
      end
      check(s_hits == 1 && s_at == AL, tg, 32'(s_at), 32'(AL));
      check(gs == es, tg, gs, es);
      check(bz_ok, "R7", {31'h0, busy}, 32'h0);
      if (rc) begin
         check(r_hits == 1 && r_at == AL + DL, "R5", 32'(r_at), 32'(AL + DL));
         check(gr == er, (es == 0) ? "R6" : "R5", gr, er);
         check(gd == (es == 0), "R6", {31'h0, gd}, {31'h0, es == 0});
      end else begin
         check(r_hits == 0, "R5", 32'(r_hits), 32'h0);
      end
   endtask

   task automatic quiet(input int n);
      int hits;
      hits = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (sum_valid || recip_valid || busy) hits++;
      end
      check(hits == 0, "R7", 32'(hits), 32'h0);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin bm[i][0] = '0; bm[i][1] = '0; end
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(!busy && !sum_valid && !recip_valid && !div_by_zero, "R1",
            {28'h0, busy, sum_valid, recip_valid, div_by_zero}, 32'h0);
      // R1: store is zero after reset -> sum equals reduce_in
      run_op(3'd1, 1'b0, 1'b0, 32'h0000_0005, 1'b0);
      // R2 / R5: 2.0 + 1.0 = 3.0, reciprocal 0x5555
      mem_wr(3'd1, 1'b0, 32'h0002_0000);
      run_op(3'd1, 1'b0, 1'b1, 32'h0001_0000, 1'b0);
      // R3: measurement minus prediction at top index
      mem_wr(3'd4, 1'b1, 32'h0005_8000);
      run_op(3'd4, 1'b1, 1'b1, 32'h0001_4000, 1'b0);
      // R4: positive and negative saturation
      mem_wr(3'd2, 1'b0, 32'h7FFF_0000);
      run_op(3'd2, 1'b0, 1'b1, 32'h0002_0000, 1'b0);
      mem_wr(3'd2, 1'b1, 32'h8000_0000);
      run_op(3'd2, 1'b1, 1'b1, 32'h0000_0001, 1'b0);
      // R6: zero sum
      mem_wr(3'd3, 1'b0, 32'h0000_0005);
      run_op(3'd3, 1'b0, 1'b1, 32'hFFFF_FFFB, 1'b0);
      // R5: +1 and -1 LSB sums clamp the magnitude
      run_op(3'd3, 1'b0, 1'b1, 32'hFFFF_FFFC, 1'b0);
      run_op(3'd3, 1'b1, 1'b1, 32'h0000_0001, 1'b0);
      // R8: out-of-range writes dropped, reads give zero operand
      mem_wr(3'd0, 1'b0, 32'h1111_0000);
      mem_wr(3'd5, 1'b1, 32'h2222_0000);
      run_op(3'd0, 1'b0, 1'b1, 32'h0003_0000, 1'b0);
      run_op(3'd5, 1'b1, 1'b0, 32'h0003_0000, 1'b0);
      run_op(3'd7, 1'b0, 1'b0, 32'h0000_0100, 1'b0);
      // R8: in-range words untouched by those writes
      run_op(3'd1, 1'b0, 1'b0, 32'h0, 1'b0);
      // R7: start while busy is ignored
      run_op(3'd1, 1'b0, 1'b1, 32'h0000_8000, 1'b1);
      quiet(AL + DL + 4);
      // random mix
      for (int t = 0; t < 60; t++) begin
         logic [2:0] ix;
         logic [31:0] d, r;
         ix = ($urandom % 8 == 0) ? 3'($urandom % 8) : 3'(1 + $urandom % NP);
         d  = ($urandom % 2) ? $urandom : 32'($signed($urandom % 32'h0010_0000) - 32'sh0008_0000);
         r  = ($urandom % 2) ? $urandom : 32'($signed($urandom % 32'h0010_0000) - 32'sh0008_0000);
         if ($urandom % 2) mem_wr(3'(1 + $urandom % NP), 1'($urandom % 2), d);
         run_op(ix, 1'($urandom % 2), 1'($urandom % 2), r, 1'b0);
      end
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R7 actual=%h expected=%h", 32'h1, 32'h0);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule